// File: doc/BRIEF.md
# ADC Serial Control Port

This block is the digital front of a multi-channel converter's serial port. A host lowers chip select and runs a full-duplex frame of sixteen serial clocks. On each falling SCLK edge the block takes one bit from `din`, most significant first. At the same time it drives `dout` with the channel address and the 12-bit result of the conversion being read. The first twelve bits form a control word. Its top bit decides whether the word is kept at all. The word sets the next channel, the coding of the next result, the input range, the power mode, two sequencer flags, and how `dout` is left once the frame is over.

The block runs entirely on the system clock `clk`. `cs_n` and `sclk` are sampled as ordinary synchronous inputs, and their falling edges are detected inside the block. Every output is a register. The raw conversion result arrives as unsigned straight binary on `result_i` and is latched when chip select falls. The serial output is described by three signals: data, strong enable and weak enable.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While `rst` is high, every output goes to zero on the next clock: the control fields, `chan_sel_o`, `dout_o`, `dout_oe_o` and `dout_weak_o`. Reset coding is therefore two's complement and the output is three-stated.
- R2: Only the bits taken on the first 12 SCLK falling edges after chip select falls are captured, MSB first. Bits on edges 13 to 16 have no effect on any field.
- R3: If captured bit 11 (the write flag) is 0, no control field and no channel select changes in that frame.
- R4: The captured word is decoded as follows. Bit 10 goes to `seq_o`. Bits 9:6 are the channel address. Bits 5:4 go to `pm_o`. Bit 3 goes to `shadow_o`. Bit 2 is the end-of-frame weak-drive select. Bit 1 goes to `range_o`. Bit 0 goes to `coding_o`.
- R5: The control fields keep their old values through the 15th falling edge. They take the new word one clock after the 16th falling edge is detected.
- R6: On the clock after chip select falls, `dout_oe_o` rises and `dout_o` shows the first frame bit. Each later falling edge moves `dout_o` on by one bit. The 16 bits are the channel address in effect at chip-select fall (4 bits, MSB first), followed by the 12-bit coded result, MSB first.
- R7: If `coding_o` is 1 when the frame starts, the result is sent unchanged (straight binary). If it is 0, the result MSB is inverted (two's complement). A coding bit written in a frame applies from the next frame on.
- R8: `chan_sel_o` takes the new address after the 14th falling edge, and only if the write flag is 1. It changes at no other time.
- R9: After the 16th falling edge, `dout_oe_o` drops. If the weak-drive bit is 1 in the register just updated, `dout_weak_o` rises and `dout_o` shows bit 3 of `chan_sel_o`. Otherwise `dout_weak_o` and `dout_o` are 0. This state holds until the next chip-select fall.
- R10: If chip select rises before the 16th falling edge, the control fields stay unchanged and `dout_oe_o` and `dout_weak_o` fall. `chan_sel_o` also stays unchanged if the 14th edge was not reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle high |
| din | input | 1 | Serial control data |
| result_i | input | RES_W | Raw unsigned conversion result |
| dout_o | output | 1 | Serial output data |
| dout_oe_o | output | 1 | Strong drive enable for dout |
| dout_weak_o | output | 1 | Weak drive enable for dout |
| chan_sel_o | output | ADDR_W | Multiplexer channel select |
| seq_o | output | 1 | Stored sequencer flag |
| shadow_o | output | 1 | Stored shadow flag |
| pm_o | output | 2 | Stored power mode |
| range_o | output | 1 | Stored input range select |
| coding_o | output | 1 | Stored output coding select |

## Verification
The bench builds the block with the defaults: ADDR_W 4, RES_W 12 and MUX_EDGE 14. With these values the capture window (12 edges), the mux switch (edge 14) and the frame end (edge 16) are three distinct points. The bench aborts frames before and after edge 14, so it can tell apart a channel select that moved early from a control register that was committed early. Results with both MSB values, sent under each coding, show whether the coding setting is applied one frame late as required.

// File: rtl/adc_sctl_pkg.sv
package adc_sctl_pkg;
  localparam int P_CODING  = 0;
  localparam int P_RANGE   = 1;
  localparam int P_WEAK    = 2;
  localparam int P_SHADOW  = 3;
  localparam int P_PM_LO   = 4;
  localparam int P_ADDR_LO = 6;

  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_STRONG = 2'd1,
    DRV_WEAK   = 2'd2
  } drive_e;
endpackage

// File: rtl/adc_sctl_edges.sv
module adc_sctl_edges (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall
);
  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign sclk_fall = sclk_q & ~sclk & ~cs_n;
endmodule

// File: rtl/adc_sctl_frame.sv
module adc_sctl_frame #(
  parameter int CTRL_W    = 12,
  parameter int FRAME_LEN = 16,
  parameter int MUX_EDGE  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              din,
  output logic [CTRL_W-1:0] word_o,
  output logic              shift_stb,
  output logic              mux_stb,
  output logic              end_stb
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CTRL_W-1:0] cap_sr;
  logic             fall_ok;

  assign fall_ok   = sclk_fall & active;
  assign shift_stb = fall_ok;
  assign mux_stb   = fall_ok && (cnt == CNT_W'(MUX_EDGE - 1));
  assign end_stb   = fall_ok && (cnt == CNT_W'(FRAME_LEN - 1));
  assign word_o    = cap_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      cap_sr <= '0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (fall_ok) begin
      cnt <= cnt + 1'b1;
      if (cnt < CNT_W'(CTRL_W))
        cap_sr <= {cap_sr[CTRL_W-2:0], din};
      if (cnt == CNT_W'(FRAME_LEN - 1))
        active <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sctl_regs.sv
module adc_sctl_regs
  import adc_sctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CTRL_W = ADDR_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] word_i,
  input  logic              mux_stb,
  input  logic              end_stb,
  output logic [ADDR_W-1:0] chan_sel_o,
  output logic [CTRL_W-2:0] ctrl_o,
  output logic              weak_next_o
);
  localparam int P_WRITE = CTRL_W - 1;

  logic wr_en;
  assign wr_en = word_i[P_WRITE];

  assign weak_next_o = wr_en ? word_i[P_WEAK] : ctrl_o[P_WEAK];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_sel_o <= '0;
      ctrl_o     <= '0;
    end else begin
      if (mux_stb && wr_en)
        chan_sel_o <= word_i[P_ADDR_LO +: ADDR_W];
      if (end_stb && wr_en)
        ctrl_o <= word_i[CTRL_W-2:0];
    end
  end
endmodule

// File: rtl/adc_sctl_tx.sv
module adc_sctl_tx
  import adc_sctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RES_W  = 12,
  localparam int FRAME_LEN = ADDR_W + RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              shift_stb,
  input  logic              end_stb,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              coding_i,
  input  logic              weak_next_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              dout_weak_o
);
  drive_e                 drv;
  logic [FRAME_LEN-1:0]   tx_sr;
  logic [RES_W-1:0]       coded;
  logic [FRAME_LEN-1:0]   load;

  assign coded = coding_i ? result_i : {~result_i[RES_W-1], result_i[RES_W-2:0]};
  assign load  = {chan_i, coded};

  always_ff @(posedge clk) begin
    if (rst) begin
      drv    <= DRV_OFF;
      tx_sr  <= '0;
      dout_o <= 1'b0;
    end else if (cs_fall) begin
      drv    <= DRV_STRONG;
      dout_o <= load[FRAME_LEN-1];
      tx_sr  <= {load[FRAME_LEN-2:0], 1'b0};
    end else if (end_stb) begin
      drv    <= weak_next_i ? DRV_WEAK : DRV_OFF;
      dout_o <= weak_next_i & chan_i[ADDR_W-1];
    end else if (shift_stb) begin
      dout_o <= tx_sr[FRAME_LEN-1];
      tx_sr  <= {tx_sr[FRAME_LEN-2:0], 1'b0};
    end else if (cs_rise && drv == DRV_STRONG) begin
      drv <= DRV_OFF;
    end
  end

  assign dout_oe_o   = (drv == DRV_STRONG);
  assign dout_weak_o = (drv == DRV_WEAK);
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_sctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RES_W    = 12,
  parameter int MUX_EDGE = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              dout_weak_o,
  output logic [ADDR_W-1:0] chan_sel_o,
  output logic              seq_o,
  output logic              shadow_o,
  output logic [1:0]        pm_o,
  output logic              range_o,
  output logic              coding_o
);
  localparam int CTRL_W    = ADDR_W + 8;
  localparam int FRAME_LEN = ADDR_W + RES_W;

  logic              cs_fall, cs_rise, sclk_fall;
  logic [CTRL_W-1:0] word;
  logic              shift_stb, mux_stb, end_stb;
  logic [CTRL_W-2:0] ctrl;
  logic              weak_next;

  adc_sctl_edges edges_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall)
  );

  adc_sctl_frame #(
    .CTRL_W(CTRL_W), .FRAME_LEN(FRAME_LEN), .MUX_EDGE(MUX_EDGE)
  ) frame_i (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .din(din), .word_o(word),
    .shift_stb(shift_stb), .mux_stb(mux_stb), .end_stb(end_stb)
  );

  adc_sctl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .word_i(word), .mux_stb(mux_stb),
    .end_stb(end_stb), .chan_sel_o(chan_sel_o), .ctrl_o(ctrl),
    .weak_next_o(weak_next)
  );

  adc_sctl_tx #(.ADDR_W(ADDR_W), .RES_W(RES_W)) tx_i (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .shift_stb(shift_stb), .end_stb(end_stb), .chan_i(chan_sel_o),
    .result_i(result_i), .coding_i(ctrl[P_CODING]), .weak_next_i(weak_next),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .dout_weak_o(dout_weak_o)
  );

  assign seq_o    = ctrl[CTRL_W-2];
  assign shadow_o = ctrl[P_SHADOW];
  assign pm_o     = ctrl[P_PM_LO +: 2];
  assign range_o  = ctrl[P_RANGE];
  assign coding_o = ctrl[P_CODING];
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              dout_oe_o,
  input logic              dout_weak_o,
  input logic [ADDR_W-1:0] chan_sel_o,
  input logic              seq_o,
  input logic              shadow_o,
  input logic [1:0]        pm_o,
  input logic              range_o,
  input logic              coding_o
);
  logic [5:0] fields;
  assign fields = {seq_o, shadow_o, pm_o, range_o, coding_o};

  // R1: reset leaves the serial output undriven
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dout_oe_o && !dout_weak_o));

  // R9: strong and weak drive never overlap
  a_r9_drive_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dout_oe_o && dout_weak_o));

  // R8: channel select moves only right after a detected falling SCLK edge
  a_r8_chan_on_fall: assert property (@(posedge clk) disable iff (rst)
    (chan_sel_o != $past(chan_sel_o)) |->
      ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1 && $past(cs_n) == 1'b0));

  // R5: control fields move only right after a detected falling SCLK edge
  a_r5_fields_on_fall: assert property (@(posedge clk) disable iff (rst)
    (fields != $past(fields)) |->
      ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1 && $past(cs_n) == 1'b0));

  // R6: strong drive starts only after chip select is low
  a_r6_oe_after_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe_o) |-> ($past(cs_n) == 1'b0));

  // R10: chip select rising ends strong drive
  a_r10_cs_rise_release: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) == 1'b0) |=> !dout_oe_o);
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
  .dout_oe_o(dout_oe_o), .dout_weak_o(dout_weak_o), .chan_sel_o(chan_sel_o),
  .seq_o(seq_o), .shadow_o(shadow_o), .pm_o(pm_o), .range_o(range_o),
  .coding_o(coding_o)
);

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int RES_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic [RES_W-1:0] result_i = '0;
  logic dout_o, dout_oe_o, dout_weak_o;
  logic [ADDR_W-1:0] chan_sel_o;
  logic seq_o, shadow_o, range_o, coding_o;
  logic [1:0] pm_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_ctrl = '0;
  logic [11:0] m_cap = '0;
  logic [3:0]  m_chan = '0;
  bit m_oe = 0, m_weak = 0, m_dout = 0, m_active = 0;
  int m_cnt = 0;
  bit mp_cs = 1, mp_sclk = 1;
  bit q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result_i(result_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .dout_weak_o(dout_weak_o), .chan_sel_o(chan_sel_o), .seq_o(seq_o),
    .shadow_o(shadow_o), .pm_o(pm_o), .range_o(range_o), .coding_o(coding_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] port_fields();
    return {seq_o, pm_o, shadow_o, range_o, coding_o};
  endfunction

  function automatic logic [5:0] word_fields(input logic [11:0] w);
    return {w[10], w[5:4], w[3], w[1], w[0]};
  endfunction

  function automatic logic [11:0] coded(input logic [11:0] r, input bit cod);
    return cod ? r : {~r[11], r[10:0]};
  endfunction

  task automatic step(input bit cs, input bit sc, input bit d);
    logic [15:0] v;
    @(negedge clk);
    cs_n = cs; sclk = sc; din = d;
    if (mp_cs && !cs) begin
      m_active = 1; m_cnt = 0;
      v = {m_chan, coded(result_i, m_ctrl[0])};
      q.delete();
      for (int i = 15; i >= 0; i--) q.push_back(v[i]);
      m_dout = q.pop_front(); m_oe = 1; m_weak = 0;
    end else if (!mp_cs && cs) begin
      m_active = 0;
      if (m_oe) begin m_oe = 0; m_weak = 0; end
    end else if (mp_sclk && !sc && !cs && m_active) begin
      if (m_cnt < 12) m_cap = {m_cap[10:0], d};
      if (m_cnt == 13 && m_cap[11]) m_chan = m_cap[9:6];
      if (m_cnt == 15) begin
        if (m_cap[11]) m_ctrl = m_cap;
        m_active = 0; m_oe = 0; m_weak = m_ctrl[2];
        m_dout = m_weak ? m_chan[3] : 1'b0;
      end else begin
        m_dout = q.pop_front();
      end
      m_cnt++;
    end
    mp_cs = cs; mp_sclk = sc;
    @(posedge clk); #1;
    check(dout_oe_o == m_oe && dout_weak_o == m_weak, "R9 drive",
          {dout_oe_o, dout_weak_o}, {m_oe, m_weak});
    if (m_oe || m_weak) check(dout_o == m_dout, "R6 dout", dout_o, m_dout);
    check(chan_sel_o == m_chan, "R8 chan", chan_sel_o, m_chan);
    check(port_fields() == word_fields(m_ctrl), "R4 fields",
          port_fields(), word_fields(m_ctrl));
  endtask

  // frame: drives word on first 12 falls, ones afterwards
  task automatic frame(input logic [11:0] w, input logic [11:0] res, input int nfalls);
    logic [15:0] got;
    logic [15:0] exp;
    logic [3:0] chan0;
    logic [5:0] f0;
    bit d;
    got = '0;
    chan0 = chan_sel_o; f0 = port_fields();
    exp = {chan0, coded(res, coding_o)};
    result_i = res;
    step(0, 1, 0);
    got[15] = dout_o;
    for (int i = 0; i < nfalls; i++) begin
      d = (i < 12) ? w[11 - i] : 1'b1;
      step(0, 0, d);
      if (i < 15) got[14 - i] = dout_o;
      if (i == 12) check(chan_sel_o == chan0, "R8 before edge 14", chan_sel_o, chan0);
      if (i == 13) check(chan_sel_o == (w[11] ? w[9:6] : chan0), "R8 at edge 14",
                         chan_sel_o, w[11] ? w[9:6] : chan0);
      if (i == 14) check(port_fields() == f0, "R5 held at edge 15", port_fields(), f0);
      step(0, 0, d);
      step(0, 1, d);
      step(0, 1, d);
    end
    if (nfalls == 16) check(got == exp, "R6 frame bits", got, exp);
    step(1, 1, 0);
    step(1, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({dout_oe_o, dout_weak_o, dout_o, chan_sel_o, port_fields()} == '0,
          "R1 reset", {dout_oe_o, dout_weak_o, dout_o, chan_sel_o, port_fields()}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;

    // write: seq1 addr A pm2 shadow1 weak1 range1 coding0
    frame(12'hEAE, 12'h123, 16);
    check(port_fields() == 6'b1_10_1_1_0, "R4 decode", port_fields(), 6'b110110);
    check(chan_sel_o == 4'hA, "R4 address", chan_sel_o, 4'hA);
    check(dout_weak_o && !dout_oe_o && dout_o, "R9 weak hold",
          {dout_oe_o, dout_weak_o, dout_o}, 3'b011);
    check(range_o == 1'b1, "R5 committed", range_o, 1);

    // write coding1, weak0, addr 3; result read under old coding (two's)
    frame(12'h8C1, 12'hABC, 16);
    check(coding_o == 1'b1 && chan_sel_o == 4'h3, "R2 tail ignored",
          {coding_o, chan_sel_o}, 5'h13);
    check(!dout_weak_o && !dout_oe_o, "R9 tristate", {dout_oe_o, dout_weak_o}, 0);

    // write flag 0: nothing changes; result now straight binary
    frame(12'h7FF, 12'hABC, 16);
    check(port_fields() == 6'b0_00_0_0_1, "R3 no write", port_fields(), 6'b000001);
    check(chan_sel_o == 4'h3, "R3 chan kept", chan_sel_o, 4'h3);
    frame(12'h7FF, 12'h7F0, 16);

    // abort before edge 14
    frame(12'hBC0, 12'h000, 10);
    check(chan_sel_o == 4'h3 && coding_o == 1'b1, "R10 early abort",
          {chan_sel_o, coding_o}, 5'h07);
    check(!dout_oe_o && !dout_weak_o, "R10 released", {dout_oe_o, dout_weak_o}, 0);

    // abort after edge 14
    frame(12'hBC0, 12'h000, 15);
    check(chan_sel_o == 4'hF, "R10 late abort chan", chan_sel_o, 4'hF);
    check(port_fields() == 6'b000001, "R10 late abort fields", port_fields(), 6'b000001);

    // coding 1 result MSB set: straight (R7), then switch to coding0
    frame(12'h800, 12'h9A5, 16);
    check(coding_o == 1'b0 && chan_sel_o == 4'h0, "R7 coding written",
          {coding_o, chan_sel_o}, 0);
    frame(12'h7FF, 12'h9A5, 16);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule